// File: doc/BRIEF.md
# MMIO-to-LPC I/O Bridge

A memory-mapped host controller that turns a handful of 32-bit register writes into a burst of byte-wide LPC I/O cycles. Software stages a burst before launching it. It sets a cycle count, a command (direction, cycle type, and whether the port address stays fixed or steps up), a 16-bit port address and, for writes, the outgoing bytes. It then writes the launch register. The block frames each cycle on the four-bit multiplexed LPC bus and honours the peripheral's SYNC handshake, including wait codes. Bytes returned by reads are gathered in a small buffer that software drains one byte per access.

The status register shows whether the engine is idle and whether the last burst finished cleanly. A peripheral error SYNC or an over-long wait ends the burst early, leaves the engine idle and clears the success flag. A sticky done flag, cleared by writing one, can drive an interrupt line when enabled. The LPC side runs on the register clock.

Top module: `lpc_io_bridge`

## Requirements
- R1: Out of reset the status register (offset 0x04) reads 0x1 (bit 0 idle set, bit 1 success clear), irq is low, lframe_n is high and lad_oe is low.
- R2: A register write to offset 0x00 with bit 0 set, while idle, launches a burst; status bit 0 reads 0 until the burst ends, and a clean end leaves status at 0x3.
- R3: Every bus cycle opens with one clock of lframe_n low with 0000 on lad_out, then a direction nibble (0000 read, 0010 write), then the 16-bit port address as four nibbles, most significant first.
- R4: A write cycle sends its byte low nibble first; the bytes come from the write buffer in the order they were pushed through offset 0x24 (bits 7:0).
- R5: Read cycles sample their byte low nibble first after a ready SYNC; reads of offset 0x28 return the collected bytes in bits 7:0, one per access, in cycle order.
- R6: Command register (offset 0x14) bit 3 set keeps every cycle of a burst on the programmed address; bit 3 clear adds one per cycle. Bit 0 is the direction (1 write).
- R7: SYNC codes 0101 and 0110 stretch a cycle; up to 256 consecutive wait codes are tolerated and the burst still completes.
- R8: A SYNC of 1010 aborts the burst: no further cycles run, the engine is idle and status bit 1 is clear.
- R9: A 257th consecutive wait code aborts the burst the same way.
- R10: The length register (offset 0x10) holds the cycle count; written values above 16 read back as 16, and a length of 0 completes at once with success and no bus cycle.
- R11: Offset 0x08 bit 0 enables the interrupt and bit 1 is a done flag set at the end of every burst (success or failure) and cleared by writing 1; irq is high while both are set.
- R12: While a burst runs, writes to length, command, address and write data are ignored, and a further launch has no effect.
- R13: Reading offset 0x28 with no unread byte returns 0 and leaves collected bytes and their order intact.
- R14: A command whose type field (bits 2:1) is non-zero fails at launch: no bus cycle, idle, status bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and LPC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the read buffer at 0x28) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| irq | output | 1 | Burst-done interrupt |
| lframe_n | output | 1 | LPC frame strobe, active low |
| lad_out | output | 4 | LPC address/data nibble driven by the host |
| lad_oe | output | 1 | High while the host drives the nibble bus |
| lad_in | input | 4 | LPC nibble bus as seen from the peripheral side |

## Verification
The bench acts as an LPC peripheral. It decodes every frame and answers with programmable wait counts, an error SYNC on a chosen cycle, or read bytes derived from the address and cycle index. The wait threshold is probed at exactly 256 and 257 codes. A design with an off-by-one counter would either fail a legal burst or accept an over-long one. Error aborts are checked by counting frames, since an engine that carried on would add frames after the failing one. Launches and register writes during a busy burst are checked by reading the registers and counting frames, which exposes any state they corrupted. Drained and empty read-buffer accesses would show stale bytes if the empty test were missing.

// File: rtl/lpc_bridge_pkg.sv
package lpc_bridge_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_GO    = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_IRQ   = 8'h08;
  localparam logic [7:0] OFS_LEN   = 8'h10;
  localparam logic [7:0] OFS_CMD   = 8'h14;
  localparam logic [7:0] OFS_PORT  = 8'h20;
  localparam logic [7:0] OFS_WBYTE = 8'h24;
  localparam logic [7:0] OFS_RBYTE = 8'h28;

  // bus nibble codes
  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] NIB_IO_RD  = 4'h0;
  localparam logic [3:0] NIB_IO_WR  = 4'h2;
  localparam logic [3:0] NIB_PARK   = 4'hF;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_WSHRT = 4'h5;
  localparam logic [3:0] SYNC_WLONG = 4'h6;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START,
    PH_CTDIR,
    PH_ADDR,
    PH_WDATA,
    PH_TAR_H,
    PH_SYNC,
    PH_RDATA,
    PH_TAR_P
  } lpc_phase_e;

endpackage

// File: rtl/lpc_byte_buf.sv
module lpc_byte_buf #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wbyte,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rbyte
);

  logic [7:0] slot [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (widx == IDX_W'(gi));
    always_ff @(posedge clk) begin
      if (slot_en) slot[gi] <= wbyte;
    end
  end

  assign rbyte = slot[ridx];

endmodule

// File: rtl/lpc_regs.sv
module lpc_regs
  import lpc_bridge_pkg::*;
#(
  parameter int MAX_BURST = 16,
  parameter int ADDR_W    = 16,
  localparam int LEN_W    = $clog2(MAX_BURST + 1),
  localparam int IDX_W    = $clog2(MAX_BURST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  // engine side
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic              rb_we,
  input  logic [7:0]        rb_rbyte,
  output logic              go,
  output logic [LEN_W-1:0]  cfg_len,
  output logic              cfg_dir,
  output logic [1:0]        cfg_type,
  output logic              cfg_fixed,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic              wb_we,
  output logic [IDX_W-1:0]  wb_widx,
  output logic [IDX_W-1:0]  rb_widx,
  output logic [IDX_W-1:0]  rb_ridx
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BURST);

  logic [LEN_W-1:0]  len_q, len_d;
  logic              dir_q, dir_d;
  logic [1:0]        type_q, type_d;
  logic              fixed_q, fixed_d;
  logic [ADDR_W-1:0] port_q, port_d;
  logic [LEN_W-1:0]  wcnt_q, wcnt_d;
  logic [LEN_W-1:0]  rcnt_q, rcnt_d;
  logic [LEN_W-1:0]  rptr_q, rptr_d;
  logic              ok_q, ok_d;
  logic              ien_q, ien_d;
  logic              dflag_q, dflag_d;
  logic              cfg_wr;
  logic              have_byte;
  logic              pop;

  assign cfg_wr    = reg_wr && !eng_busy;
  assign have_byte = rptr_q < rcnt_q;
  assign pop       = reg_rd && (reg_addr == OFS_RBYTE) && have_byte;
  assign go        = reg_wr && (reg_addr == OFS_GO) && reg_wdata[0] && !eng_busy;
  assign wb_we     = cfg_wr && (reg_addr == OFS_WBYTE) && (wcnt_q < LEN_MAX);

  // next-state
  always_comb begin
    len_d   = len_q;
    dir_d   = dir_q;
    type_d  = type_q;
    fixed_d = fixed_q;
    port_d  = port_q;
    wcnt_d  = wcnt_q;
    rcnt_d  = rcnt_q;
    rptr_d  = rptr_q;
    ok_d    = ok_q;
    ien_d   = ien_q;
    dflag_d = dflag_q;

    if (cfg_wr && (reg_addr == OFS_LEN)) begin
      len_d = (reg_wdata > 32'(MAX_BURST)) ? LEN_MAX : reg_wdata[LEN_W-1:0];
    end
    if (cfg_wr && (reg_addr == OFS_CMD)) begin
      dir_d   = reg_wdata[0];
      type_d  = reg_wdata[2:1];
      fixed_d = reg_wdata[3];
    end
    if (cfg_wr && (reg_addr == OFS_PORT)) begin
      port_d = reg_wdata[ADDR_W-1:0];
    end
    if (wb_we) begin
      wcnt_d = wcnt_q + 1'b1;
    end
    if (reg_wr && (reg_addr == OFS_IRQ)) begin
      ien_d = reg_wdata[0];
      if (reg_wdata[1]) dflag_d = 1'b0;
    end
    if (pop) begin
      rptr_d = rptr_q + 1'b1;
    end
    if (rb_we) begin
      rcnt_d = rcnt_q + 1'b1;
    end
    if (go) begin
      wcnt_d = '0;
      rcnt_d = '0;
      rptr_d = '0;
      ok_d   = 1'b0;
    end
    if (eng_done) begin
      ok_d    = eng_ok;
      dflag_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      dir_q   <= 1'b0;
      type_q  <= '0;
      fixed_q <= 1'b0;
      port_q  <= '0;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      rptr_q  <= '0;
      ok_q    <= 1'b0;
      ien_q   <= 1'b0;
      dflag_q <= 1'b0;
    end else begin
      len_q   <= len_d;
      dir_q   <= dir_d;
      type_q  <= type_d;
      fixed_q <= fixed_d;
      port_q  <= port_d;
      wcnt_q  <= wcnt_d;
      rcnt_q  <= rcnt_d;
      rptr_q  <= rptr_d;
      ok_q    <= ok_d;
      ien_q   <= ien_d;
      dflag_q <= dflag_d;
    end
  end

  // read mux
  always_comb begin
    case (reg_addr)
      OFS_STAT:  reg_rdata = {30'd0, ok_q, !eng_busy};
      OFS_IRQ:   reg_rdata = {30'd0, dflag_q, ien_q};
      OFS_LEN:   reg_rdata = 32'(len_q);
      OFS_CMD:   reg_rdata = {28'd0, fixed_q, type_q, dir_q};
      OFS_PORT:  reg_rdata = 32'(port_q);
      OFS_RBYTE: reg_rdata = have_byte ? {24'd0, rb_rbyte} : 32'd0;
      default:   reg_rdata = 32'd0;
    endcase
  end

  assign irq       = ien_q && dflag_q;
  assign cfg_len   = len_q;
  assign cfg_dir   = dir_q;
  assign cfg_type  = type_q;
  assign cfg_fixed = fixed_q;
  assign cfg_addr  = port_q;
  assign wb_widx   = wcnt_q[IDX_W-1:0];
  assign rb_widx   = rcnt_q[IDX_W-1:0];
  assign rb_ridx   = rptr_q[IDX_W-1:0];

endmodule

// File: rtl/lpc_cycle_engine.sv
module lpc_cycle_engine
  import lpc_bridge_pkg::*;
#(
  parameter int MAX_BURST  = 16,
  parameter int ADDR_W     = 16,
  parameter int WAIT_LIMIT = 256,
  localparam int LEN_W     = $clog2(MAX_BURST + 1),
  localparam int IDX_W     = $clog2(MAX_BURST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_dir,
  input  logic [1:0]        cfg_type,
  input  logic              cfg_fixed,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        wb_rbyte,
  input  logic [3:0]        lad_in,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [IDX_W-1:0]  wb_ridx,
  output logic              rb_we,
  output logic [7:0]        rb_wbyte,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              lframe_n
);

  localparam int NIBS   = ADDR_W / 4;
  localparam int NIB_W  = (NIBS > 2) ? $clog2(NIBS) : 1;
  localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [NIB_W-1:0]  NIB_LAST = NIB_W'(NIBS - 1);
  localparam logic [WAIT_W-1:0] WAIT_TOP = WAIT_W'(WAIT_LIMIT);

  lpc_phase_e        ph_q, ph_d;
  logic [NIB_W-1:0]  nib_q, nib_d;
  logic [LEN_W-1:0]  cyc_q, cyc_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [3:0]        rlow_q, rlow_d;
  logic              dir_q, dir_d;
  logic              fixed_q, fixed_d;
  logic [LEN_W-1:0]  cyc_nx;

  assign cyc_nx = cyc_q + 1'b1;

  // next-state
  always_comb begin
    ph_d    = ph_q;
    nib_d   = nib_q;
    cyc_d   = cyc_q;
    len_d   = len_q;
    addr_d  = addr_q;
    wait_d  = wait_q;
    rlow_d  = rlow_q;
    dir_d   = dir_q;
    fixed_d = fixed_q;
    done    = 1'b0;
    ok      = 1'b0;
    rb_we   = 1'b0;

    unique case (ph_q)
      PH_IDLE: begin
        if (go) begin
          if (cfg_type != 2'b00) begin
            done = 1'b1;
          end else if (cfg_len == '0) begin
            done = 1'b1;
            ok   = 1'b1;
          end else begin
            ph_d    = PH_START;
            len_d   = cfg_len;
            addr_d  = cfg_addr;
            dir_d   = cfg_dir;
            fixed_d = cfg_fixed;
            cyc_d   = '0;
          end
        end
      end
      PH_START: ph_d = PH_CTDIR;
      PH_CTDIR: begin
        ph_d  = PH_ADDR;
        nib_d = '0;
      end
      PH_ADDR: begin
        if (nib_q == NIB_LAST) begin
          nib_d = '0;
          ph_d  = dir_q ? PH_WDATA : PH_TAR_H;
        end else begin
          nib_d = nib_q + 1'b1;
        end
      end
      PH_WDATA: begin
        if (nib_q != '0) begin
          nib_d = '0;
          ph_d  = PH_TAR_H;
        end else begin
          nib_d = NIB_W'(1);
        end
      end
      PH_TAR_H: begin
        if (nib_q != '0) begin
          nib_d  = '0;
          wait_d = '0;
          ph_d   = PH_SYNC;
        end else begin
          nib_d = NIB_W'(1);
        end
      end
      PH_SYNC: begin
        if (lad_in == SYNC_READY) begin
          ph_d = dir_q ? PH_TAR_P : PH_RDATA;
        end else if ((lad_in == SYNC_WSHRT || lad_in == SYNC_WLONG) && (wait_q != WAIT_TOP)) begin
          wait_d = wait_q + 1'b1;
        end else begin
          // error code, unknown code or wait budget exhausted
          ph_d = PH_IDLE;
          done = 1'b1;
        end
      end
      PH_RDATA: begin
        if (nib_q != '0) begin
          rb_we = 1'b1;
          nib_d = '0;
          ph_d  = PH_TAR_P;
        end else begin
          rlow_d = lad_in;
          nib_d  = NIB_W'(1);
        end
      end
      PH_TAR_P: begin
        if (nib_q != '0) begin
          nib_d = '0;
          cyc_d = cyc_nx;
          if (!fixed_q) addr_d = addr_q + 1'b1;
          if (cyc_nx == len_q) begin
            ph_d = PH_IDLE;
            done = 1'b1;
            ok   = 1'b1;
          end else begin
            ph_d = PH_START;
          end
        end else begin
          nib_d = NIB_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      nib_q   <= '0;
      cyc_q   <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      wait_q  <= '0;
      rlow_q  <= '0;
      dir_q   <= 1'b0;
      fixed_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      nib_q   <= nib_d;
      cyc_q   <= cyc_d;
      len_q   <= len_d;
      addr_q  <= addr_d;
      wait_q  <= wait_d;
      rlow_q  <= rlow_d;
      dir_q   <= dir_d;
      fixed_q <= fixed_d;
    end
  end

  // bus drive
  always_comb begin
    lad_out = NIB_PARK;
    lad_oe  = 1'b0;
    unique case (ph_q)
      PH_START: begin
        lad_out = NIB_START;
        lad_oe  = 1'b1;
      end
      PH_CTDIR: begin
        lad_out = dir_q ? NIB_IO_WR : NIB_IO_RD;
        lad_oe  = 1'b1;
      end
      PH_ADDR: begin
        lad_out = addr_q[(NIBS - 1 - int'(nib_q)) * 4 +: 4];
        lad_oe  = 1'b1;
      end
      PH_WDATA: begin
        lad_out = (nib_q == '0) ? wb_rbyte[3:0] : wb_rbyte[7:4];
        lad_oe  = 1'b1;
      end
      PH_TAR_H: begin
        lad_out = NIB_PARK;
        lad_oe  = (nib_q == '0);
      end
      default: begin
        lad_out = NIB_PARK;
        lad_oe  = 1'b0;
      end
    endcase
  end

  assign lframe_n = (ph_q != PH_START);
  assign busy     = (ph_q != PH_IDLE);
  assign wb_ridx  = cyc_q[IDX_W-1:0];
  assign rb_wbyte = {lad_in, rlow_q};

endmodule

// File: rtl/lpc_io_bridge.sv
module lpc_io_bridge #(
  parameter int MAX_BURST  = 16,
  parameter int WAIT_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        lframe_n,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  input  logic [3:0]  lad_in
);

  localparam int ADDR_W = 16;
  localparam int LEN_W  = $clog2(MAX_BURST + 1);
  localparam int IDX_W  = $clog2(MAX_BURST);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic              eng_busy, eng_done, eng_ok, go;
  logic [LEN_W-1:0]  cfg_len;
  logic              cfg_dir, cfg_fixed;
  logic [1:0]        cfg_type;
  logic [ADDR_W-1:0] cfg_addr;
  logic              wb_we, rb_we;
  logic [IDX_W-1:0]  wb_widx, wb_ridx, rb_widx, rb_ridx;
  logic [7:0]        wb_rbyte, rb_wbyte, rb_rbyte;

  lpc_regs #(.MAX_BURST(MAX_BURST), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .eng_ok    (eng_ok),
    .rb_we     (rb_we),
    .rb_rbyte  (rb_rbyte),
    .go        (go),
    .cfg_len   (cfg_len),
    .cfg_dir   (cfg_dir),
    .cfg_type  (cfg_type),
    .cfg_fixed (cfg_fixed),
    .cfg_addr  (cfg_addr),
    .wb_we     (wb_we),
    .wb_widx   (wb_widx),
    .rb_widx   (rb_widx),
    .rb_ridx   (rb_ridx)
  );

  lpc_byte_buf #(.DEPTH(MAX_BURST), .IDX_W(IDX_W)) u_wbuf (
    .clk   (clk),
    .we    (wb_we),
    .widx  (wb_widx),
    .wbyte (reg_wdata[7:0]),
    .ridx  (wb_ridx),
    .rbyte (wb_rbyte)
  );

  lpc_byte_buf #(.DEPTH(MAX_BURST), .IDX_W(IDX_W)) u_rbuf (
    .clk   (clk),
    .we    (rb_we),
    .widx  (rb_widx),
    .wbyte (rb_wbyte),
    .ridx  (rb_ridx),
    .rbyte (rb_rbyte)
  );

  lpc_cycle_engine #(
    .MAX_BURST (MAX_BURST),
    .ADDR_W    (ADDR_W),
    .WAIT_LIMIT(WAIT_LIMIT)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .go        (go),
    .cfg_len   (cfg_len),
    .cfg_dir   (cfg_dir),
    .cfg_type  (cfg_type),
    .cfg_fixed (cfg_fixed),
    .cfg_addr  (cfg_addr),
    .wb_rbyte  (wb_rbyte),
    .lad_in    (lad_in),
    .busy      (eng_busy),
    .done      (eng_done),
    .ok        (eng_ok),
    .wb_ridx   (wb_ridx),
    .rb_we     (rb_we),
    .rb_wbyte  (rb_wbyte),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .lframe_n  (lframe_n)
  );

endmodule

// File: rtl/lpc_io_bridge_chk.sv
module lpc_io_bridge_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [7:0]       reg_addr,
  input logic             irq,
  input logic             lframe_n,
  input logic [3:0]       lad_out,
  input logic             lad_oe,
  input logic             eng_busy,
  input logic [LEN_W-1:0] cfg_len
);

  AST_FRAME_SINGLE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lframe_n); // R3

  AST_FRAME_CARRIES_START: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> (lad_oe && lad_out == 4'h0)); // R3

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (lframe_n && !lad_oe)); // R1

  AST_LAUNCH_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> !lframe_n); // R2

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == 8'h08)) |=> irq); // R11

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> $stable(cfg_len)); // R12

endmodule

bind lpc_io_bridge lpc_io_bridge_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .irq      (irq),
  .lframe_n (lframe_n),
  .lad_out  (lad_out),
  .lad_oe   (lad_oe),
  .eng_busy (eng_busy),
  .cfg_len  (cfg_len)
);

// File: tb/lpc_io_bridge_tb.sv
module lpc_io_bridge_tb;

  logic        clk, rst_n, reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, lframe_n, lad_oe;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in;

  int nchk = 0;
  int nerr = 0;

  lpc_io_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
    .lad_in(lad_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- peripheral model ----------------
  int          log_n = 0;
  logic [3:0]  log_ct   [64];
  logic [15:0] log_addr [64];
  logic [7:0]  log_wb   [64];
  int          p_wait   = 0;
  int          p_err_at = -1;

  function automatic logic [7:0] rd_pat(logic [15:0] a, int k);
    logic [31:0] kk;
    kk = 32'(k);
    return a[7:0] ^ {kk[3:0], 4'h9};
  endfunction

  initial begin
    logic [3:0]  ct, lo, hi;
    logic [15:0] a;
    logic [7:0]  rb;
    int          k;
    lad_in = 4'hF;
    forever begin
      @(negedge clk);
      if (rst_n && !lframe_n) begin
        @(negedge clk); ct = lad_out;
        a = '0;
        repeat (4) begin @(negedge clk); a = {a[11:0], lad_out}; end
        lo = 4'h0; hi = 4'h0;
        if (ct == 4'h2) begin
          @(negedge clk); lo = lad_out;
          @(negedge clk); hi = lad_out;
        end
        @(negedge clk); @(negedge clk);
        k = log_n;
        if (k < 64) begin
          log_ct[k] = ct; log_addr[k] = a; log_wb[k] = {hi, lo};
        end
        log_n++;
        for (int w = 0; w < p_wait; w++) begin
          @(negedge clk); lad_in = w[0] ? 4'h5 : 4'h6;
        end
        if (k == p_err_at) begin
          @(negedge clk); lad_in = 4'hA;
        end else begin
          @(negedge clk); lad_in = 4'h0;
          if (ct != 4'h2) begin
            rb = rd_pat(a, k);
            @(negedge clk); lad_in = rb[3:0];
            @(negedge clk); lad_in = rb[7:4];
          end
        end
        @(negedge clk); lad_in = 4'hF;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < 3000 && !s[0]; i++) rd(8'h04, s);
    repeat (12) @(negedge clk);
  endtask

  task automatic setup(int len, logic [31:0] cmd, logic [15:0] port);
    wr(8'h10, 32'(len));
    wr(8'h14, cmd);
    wr(8'h20, {16'd0, port});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); chk("R1 status after reset", d, 32'h1);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 lframe_n after reset", {31'd0, lframe_n}, 32'd1);
    chk("R1 lad_oe after reset", {31'd0, lad_oe}, 32'd0);
    rd(8'h28, d); chk("R13 empty read buffer", d, 32'd0);
  endtask

  task automatic t_write_incr();
    logic [31:0] d;
    int base;
    base = log_n;
    p_wait = 0;
    wr(8'h08, 32'h1);
    setup(3, 32'h1, 16'h02E4);
    wr(8'h24, 32'hAA); wr(8'h24, 32'hBB); wr(8'h24, 32'hCC);
    wr(8'h00, 32'h1);
    rd(8'h04, d); chk("R2 busy during burst", d & 32'h1, 32'h0);
    wait_idle();
    rd(8'h04, d); chk("R2 clean end status", d, 32'h3);
    chk("R4 write frame count", 32'(log_n - base), 32'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 write direction nibble", 32'(log_ct[base+i]), 32'h2);
      chk("R6 incrementing address", 32'(log_addr[base+i]), 32'h02E4 + 32'(i));
    end
    chk("R4 write byte 0", 32'(log_wb[base]), 32'hAA);
    chk("R4 write byte 1", 32'(log_wb[base+1]), 32'hBB);
    chk("R4 write byte 2", 32'(log_wb[base+2]), 32'hCC);
    chk("R11 irq raised", {31'd0, irq}, 32'd1);
    rd(8'h08, d); chk("R11 enable and done flag", d, 32'h3);
    wr(8'h08, 32'h3);
    rd(8'h08, d); chk("R11 done flag cleared by one", d, 32'h1);
    chk("R11 irq dropped", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_read_fixed();
    logic [31:0] d;
    int base;
    base = log_n;
    p_wait = 3;
    setup(4, 32'h8, 16'h0060);
    wr(8'h00, 32'h1);
    wait_idle();
    rd(8'h04, d); chk("R7 waits tolerated", d, 32'h3);
    chk("R6 fixed frame count", 32'(log_n - base), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 read direction nibble", 32'(log_ct[base+i]), 32'h0);
      chk("R6 fixed address", 32'(log_addr[base+i]), 32'h0060);
    end
    for (int i = 0; i < 4; i++) begin
      rd(8'h28, d); chk("R5 read byte order", d, 32'(rd_pat(16'h0060, base + i)));
    end
    rd(8'h28, d); chk("R13 drained buffer", d, 32'd0);
    rd(8'h28, d); chk("R13 drained buffer again", d, 32'd0);
    p_wait = 0;
  endtask

  task automatic t_long_read();
    logic [31:0] d;
    int base;
    base = log_n;
    wr(8'h10, 32'd40);
    rd(8'h10, d); chk("R10 length saturates", d, 32'd16);
    wr(8'h14, 32'h0);
    wr(8'h20, 32'h0100);
    wr(8'h00, 32'h1);
    wait_idle();
    chk("R10 sixteen frames", 32'(log_n - base), 32'd16);
    chk("R3 address of last frame", 32'(log_addr[base+15]), 32'h010F);
    for (int i = 0; i < 16; i++) begin
      rd(8'h28, d); chk("R5 long read byte", d, 32'(rd_pat(16'h0100 + 16'(i), base + i)));
    end
  endtask

  task automatic t_len_zero();
    logic [31:0] d;
    int base;
    base = log_n;
    setup(0, 32'h1, 16'h0070);
    wr(8'h00, 32'h1);
    rd(8'h04, d); chk("R10 zero length completes", d, 32'h3);
    repeat (20) @(negedge clk);
    chk("R10 zero length no frame", 32'(log_n - base), 32'd0);
  endtask

  task automatic t_error();
    logic [31:0] d;
    int base;
    base = log_n;
    wr(8'h08, 32'h3);
    p_err_at = base + 1;
    setup(3, 32'h0, 16'h0080);
    wr(8'h00, 32'h1);
    wait_idle();
    p_err_at = -1;
    rd(8'h04, d); chk("R8 error ends failed", d, 32'h1);
    chk("R8 no frame after error", 32'(log_n - base), 32'd2);
    rd(8'h28, d); chk("R8 byte before error kept", d, 32'(rd_pat(16'h0080, base)));
    rd(8'h28, d); chk("R13 nothing after error byte", d, 32'd0);
    rd(8'h08, d); chk("R11 done flag on failure", d, 32'h3);
    wr(8'h08, 32'h2);
  endtask

  task automatic t_wait_limit();
    logic [31:0] d;
    setup(1, 32'h1, 16'h0090);
    p_wait = 256;
    wr(8'h24, 32'h5A);
    wr(8'h00, 32'h1);
    wait_idle();
    rd(8'h04, d); chk("R7 256 waits complete", d, 32'h3);
    p_wait = 257;
    wr(8'h24, 32'h5B);
    wr(8'h00, 32'h1);
    wait_idle();
    rd(8'h04, d); chk("R9 257 waits abort", d, 32'h1);
    p_wait = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    int base;
    setup(2, 32'h1, 16'h0300);
    wr(8'h24, 32'h11); wr(8'h24, 32'h22);
    base = log_n;
    p_wait = 40;
    wr(8'h00, 32'h1);
    wr(8'h10, 32'd5);
    wr(8'h14, 32'h8);
    wr(8'h20, 32'h9999);
    wr(8'h24, 32'h77);
    wr(8'h00, 32'h1);
    wait_idle();
    p_wait = 0;
    rd(8'h10, d); chk("R12 length kept", d, 32'd2);
    rd(8'h14, d); chk("R12 command kept", d, 32'h1);
    rd(8'h20, d); chk("R12 address kept", d, 32'h0300);
    chk("R12 second launch ignored", 32'(log_n - base), 32'd2);
    chk("R12 data push ignored", 32'(log_wb[base+1]), 32'h22);
  endtask

  task automatic t_bad_type();
    logic [31:0] d;
    int base;
    base = log_n;
    setup(2, 32'h2, 16'h00A0);
    rd(8'h14, d); chk("R14 command readback", d, 32'h2);
    wr(8'h00, 32'h1);
    rd(8'h04, d); chk("R14 bad type fails", d, 32'h1);
    repeat (20) @(negedge clk);
    chk("R14 bad type no frame", 32'(log_n - base), 32'd0);
  endtask

  // ---------------- sequence ----------------
  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_incr();
    t_read_fixed();
    t_long_read();
    t_len_zero();
    t_error();
    t_wait_limit();
    t_busy_ignore();
    t_bad_type();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule